// File: doc/BRIEF.md
# Register-Driven Two-Wire Byte Master

This block is a master for a two-wire open-drain serial bus in the I2C style. Software drives it through four byte-wide registers: the data byte, the index (the word address inside the slave), the slave selector and a control/status byte. A write to the slave selector launches one complete word-addressed transfer. The transfer is either a byte write or a byte read, chosen by bit 0 of the written value.

For a write, the block sends START, the address with R/W low, the index and the data byte, then STOP. For a read, it sends the address and index, then a repeated START, then the address with R/W high. It then clocks in one byte, returns a master acknowledge bit, and ends with STOP.

SCL comes from the system clock. Each bit takes four quarter periods, so SDA moves only while SCL is low. Both lines are released when the bus is idle. If the slave does not acknowledge, the transfer is cut short with a STOP and a sticky error flag is raised. A received byte lands in the data register and sets a sticky valid flag. Software clears both flags by writing ones.

Top module: `sbus_byte_master`

## Requirements
- R1: After reset, every register reads 0x00 and both bus lines are released (neither drive-low output asserted).
- R2: Register offsets are 0 data, 1 index, 2 slave selector and 3 control/status. A write of value V to offset 2 while idle starts a transfer, with the slave address in V[7:1] and the direction in V[0] (0 write, 1 read). Status bit 0 (busy) reads 1 from the cycle after that write. Offset 2 reads back the accepted V.
- R3: A byte write puts START, {addr,0}, index and data on the bus, each byte MSB first and each followed by a slave acknowledge bit, then STOP.
- R4: A byte read puts START, {addr,0} and index on the bus, then a repeated START and {addr,1}, with a slave acknowledge after each byte. It then receives 8 bits MSB first and drives the acknowledge bit low, then sends STOP. The received byte appears at offset 0 and status bit 1 (data valid) is set.
- R5: A missing slave acknowledge on any byte ends the transfer with STOP. No further bytes or repeated START follow, status bit 2 (error) is set, data valid is not set, and busy clears.
- R6: Status bits 1 and 2 stay set until a write to offset 3 has a 1 in that bit position. A 0 in that position leaves the bit unchanged.
- R7: A write to offset 2 while busy is ignored. It neither restarts nor alters the running transfer, and offset 2 keeps the accepted value.
- R8: SCL rising edges inside a byte are 4*QDIV system clocks apart, where QDIV = CLK_HZ/(4*SCL_HZ). Within a data or acknowledge bit, SDA does not change while SCL is high.
- R9: Whenever no transfer is running, both drive-low outputs are deasserted.
- R10: Offsets 0 and 1 read back the last value written by software, except that a completed read replaces offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
Assertions check the following on every cycle:
- SDA holds steady while SCL is high inside a bit.
- Quarter-period ticks are never adjacent.
- The latched transfer parameters stay frozen while busy.
- A detected no-acknowledge leads straight to STOP.
- Both lines are released when busy falls.
- The error and valid flags are sticky.

Only the bench's scenarios, run against a behavioural slave, can show the rest:
- the exact byte sequences on the bus;
- the repeated START of a read;
- the received data reaching the data register;
- how many bytes follow a no-acknowledge at each position;
- that a write to the selector while busy is ignored;
- the measured SCL bit period.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   typedef enum logic [1:0] {
      ITEM_START = 2'd0,
      ITEM_TX    = 2'd1,
      ITEM_RX    = 2'd2,
      ITEM_STOP  = 2'd3
   } item_e;

   localparam logic [1:0] OFS_DATA  = 2'd0;
   localparam logic [1:0] OFS_INDEX = 2'd1;
   localparam logic [1:0] OFS_SLAVE = 2'd2;
   localparam logic [1:0] OFS_CTRL  = 2'd3;

   localparam int BIT_BUSY  = 0;
   localparam int BIT_VALID = 1;
   localparam int BIT_ERR   = 2;
endpackage

// File: rtl/sbus_qtick.sv
module sbus_qtick #(
   parameter int QDIV = 312
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (clr || cnt == LAST)  cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R8
endmodule

// File: rtl/sbus_engine.sv
module sbus_engine
   import sbus_pkg::*;
#(
   parameter bit MASTER_ACK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start,
   input  logic [7:0] slv_byte,
   input  logic [7:0] idx_byte,
   input  logic [7:0] dat_byte,
   input  logic       sda_in,
   output logic       busy,
   output logic       done,
   output logic       nack,
   output logic       rx_ok,
   output logic [7:0] rx_byte,
   output logic       scl_low,
   output logic       sda_low
);
   logic [2:0] step;
   logic [1:0] phase;
   logic [3:0] bitn;
   logic       rd;
   logic       ab;
   logic [7:0] rxs;
   logic [7:0] lat_slv, lat_idx, lat_dat;
   item_e      kind;
   logic [7:0] cur_tx;
   logic       rx_ack_low;
   logic [2:0] last_step;

   generate
      if (MASTER_ACK) begin : g_ack
         assign rx_ack_low = 1'b1;
      end else begin : g_nak
         assign rx_ack_low = 1'b0;
      end
   endgenerate

   assign last_step = rd ? 3'd6 : 3'd4;

   always_comb begin
      if (rd) begin
         case (step)
            3'd0, 3'd3:       kind = ITEM_START;
            3'd1, 3'd2, 3'd4: kind = ITEM_TX;
            3'd5:             kind = ITEM_RX;
            default:          kind = ITEM_STOP;
         endcase
      end else begin
         case (step)
            3'd0:             kind = ITEM_START;
            3'd1, 3'd2, 3'd3: kind = ITEM_TX;
            default:          kind = ITEM_STOP;
         endcase
      end
   end

   always_comb begin
      case (step)
         3'd1:    cur_tx = {lat_slv[7:1], 1'b0};
         3'd2:    cur_tx = lat_idx;
         3'd3:    cur_tx = lat_dat;
         3'd4:    cur_tx = {lat_slv[7:1], 1'b1};
         default: cur_tx = 8'h00;
      endcase
   end

   always_comb begin
      sda_low = 1'b0;
      if (busy) begin
         case (kind)
            ITEM_START: sda_low = phase[1];
            ITEM_STOP:  sda_low = !phase[1];
            ITEM_TX:    sda_low = bitn[3] ? 1'b0 : !cur_tx[3'd7 - bitn[2:0]];
            default:    sda_low = bitn[3] ? rx_ack_low : 1'b0;
         endcase
      end
   end

   assign scl_low = busy && (phase == 2'd0 || (phase == 2'd3 && kind != ITEM_STOP));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; step <= '0; phase <= '0; bitn <= '0;
         rd <= 1'b0; ab <= 1'b0; rxs <= '0;
         lat_slv <= '0; lat_idx <= '0; lat_dat <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1; step <= '0; phase <= '0; bitn <= '0;
               ab <= 1'b0; rd <= slv_byte[0];
               lat_slv <= slv_byte; lat_idx <= idx_byte; lat_dat <= dat_byte;
            end
         end else if (tick) begin
            if (phase != 2'd3) begin
               phase <= phase + 2'd1;
               if (phase == 2'd2) begin
                  if (kind == ITEM_TX && bitn[3] && sda_in) ab <= 1'b1;
                  if (kind == ITEM_RX && !bitn[3]) rxs <= {rxs[6:0], sda_in};
               end
            end else begin
               phase <= 2'd0;
               case (kind)
                  ITEM_START: step <= step + 3'd1;
                  ITEM_STOP: begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end
                  default: begin
                     if (bitn[3]) begin
                        bitn <= '0;
                        step <= ab ? last_step : step + 3'd1;
                     end else begin
                        bitn <= bitn + 4'd1;
                     end
                  end
               endcase
            end
         end
      end
   end

   assign nack    = ab;
   assign rx_ok   = rd && !ab;
   assign rx_byte = rxs;

   AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (kind == ITEM_TX || kind == ITEM_RX) && !scl_low && !$past(scl_low))
      |-> $stable(sda_low)); // R8
   AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(lat_slv) && $stable(lat_idx) && $stable(lat_dat))); // R7
   AST_NACK_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ab && phase == 2'd0) |-> kind == ITEM_STOP); // R5
   AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!scl_low && !sda_low)); // R9
endmodule

// File: rtl/sbus_regs.sv
module sbus_regs
   import sbus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       eng_busy,
   input  logic       eng_done,
   input  logic       eng_nack,
   input  logic       eng_rx_ok,
   input  logic [7:0] eng_rx_byte,
   output logic       start,
   output logic [7:0] slv_q,
   output logic [7:0] idx_q,
   output logic [7:0] dat_q
);
   logic valid_q, err_q;
   logic wr_ctrl;

   assign start   = wr && addr == OFS_SLAVE && !eng_busy;
   assign wr_ctrl = wr && addr == OFS_CTRL;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slv_q <= '0; idx_q <= '0; dat_q <= '0; valid_q <= 1'b0; err_q <= 1'b0;
      end else begin
         if (start) slv_q <= wdata;
         if (wr && addr == OFS_INDEX) idx_q <= wdata;
         if (eng_done && eng_rx_ok)      dat_q <= eng_rx_byte;
         else if (wr && addr == OFS_DATA) dat_q <= wdata;
         if (eng_done && eng_rx_ok)            valid_q <= 1'b1;
         else if (wr_ctrl && wdata[BIT_VALID]) valid_q <= 1'b0;
         if (eng_done && eng_nack)             err_q <= 1'b1;
         else if (wr_ctrl && wdata[BIT_ERR])   err_q <= 1'b0;
      end
   end

   always_comb begin
      case (addr)
         OFS_DATA:  rdata = dat_q;
         OFS_INDEX: rdata = idx_q;
         OFS_SLAVE: rdata = slv_q;
         default:   rdata = {5'b0, err_q, valid_q, eng_busy};
      endcase
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_q) && !($past(wr_ctrl) && $past(wdata[BIT_ERR]))) |-> err_q); // R6
   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(valid_q) && !($past(wr_ctrl) && $past(wdata[BIT_VALID]))) |-> valid_q); // R6
   AST_SLAVE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eng_busy) |-> $stable(slv_q)); // R7
endmodule

// File: rtl/sbus_byte_master.sv
module sbus_byte_master #(
   parameter int CLK_HZ     = 125_000_000,
   parameter int SCL_HZ     = 100_000,
   parameter bit MASTER_ACK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       scl_drive_low,
   output logic       sda_drive_low,
   input  logic       sda_in
);
   localparam int QDIV = CLK_HZ / (4 * SCL_HZ);

   generate
      if (SCL_HZ <= 0) begin : g_bad_scl
         $error("SCL_HZ must be positive");
      end
      if (QDIV < 2) begin : g_bad_div
         $error("CLK_HZ must be at least 8 times SCL_HZ");
      end
   endgenerate

   logic       tick, start;
   logic       busy, done, nack, rx_ok;
   logic [7:0] rx_byte, slv_q, idx_q, dat_q;

   sbus_qtick #(.QDIV(QDIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(start), .tick(tick)
   );

   sbus_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .eng_busy(busy), .eng_done(done), .eng_nack(nack),
      .eng_rx_ok(rx_ok), .eng_rx_byte(rx_byte), .start(start),
      .slv_q(slv_q), .idx_q(idx_q), .dat_q(dat_q)
   );

   sbus_engine #(.MASTER_ACK(MASTER_ACK)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .slv_byte(reg_wdata), .idx_byte(idx_q), .dat_byte(dat_q), .sda_in(sda_in),
      .busy(busy), .done(done), .nack(nack), .rx_ok(rx_ok), .rx_byte(rx_byte),
      .scl_low(scl_drive_low), .sda_low(sda_drive_low)
   );

   AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_drive_low && !sda_drive_low)); // R9
endmodule

// File: tb/sbus_byte_master_tb.sv
module sbus_byte_master_tb;
   localparam int CLK_HZ = 1_600_000;
   localparam int SCL_HZ = 100_000;
   localparam int BITP   = 4 * (CLK_HZ / (4 * SCL_HZ));
   localparam logic [6:0] SLV = 7'h50;
   localparam int NV = 7;
   // vector: {rw, addr7, index, data, nack_sel}; nack_sel 2 = slave refuses index, 3 = refuses data
   localparam logic [25:0] VEC [NV] = '{
      {1'b0, 7'h50, 8'h12, 8'hC3, 2'd0},
      {1'b1, 7'h50, 8'h34, 8'h00, 2'd0},
      {1'b0, 7'h21, 8'h77, 8'h88, 2'd0},
      {1'b1, 7'h50, 8'h9A, 8'h00, 2'd2},
      {1'b0, 7'h50, 8'h40, 8'h5E, 2'd3},
      {1'b1, 7'h50, 8'hFF, 8'h00, 2'd0},
      {1'b0, 7'h50, 8'h00, 8'hFF, 2'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       scl_drive_low, sda_drive_low;
   logic       s_drive = 1'b0;
   logic [1:0] nack_sel = 2'd0;
   int checks = 0;
   int errors = 0;

   wire scl_bus = !scl_drive_low;
   wire sda_bus = !(sda_drive_low || s_drive);

   always #4 clk = !clk;

   sbus_byte_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_in(sda_bus)
   );

   // behavioural slave, sampled on the falling clock edge
   logic p_scl = 1'b1, p_sda = 1'b1;
   logic [3:0] s_bit = 0;
   logic [2:0] s_byte = 0;
   logic [7:0] s_sh = 0, s_idx = 0, s_dat = 0, s_out = 0;
   logic s_tx = 0, s_pend = 0, s_mack = 1;
   int s_starts = 0, s_nb = 0, cyc = 0, s_last = 0, s_gap = 0;
   wire [7:0] rd_val = s_idx ^ 8'h5A;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      p_scl <= scl_bus;
      p_sda <= sda_bus;
      if (!rst_n) begin
         s_bit <= 0; s_tx <= 0; s_drive <= 0; s_pend <= 0;
      end else if (scl_bus && p_scl && p_sda && !sda_bus) begin
         s_starts <= s_starts + 1; s_bit <= 0; s_byte <= 0;
         s_tx <= 0; s_pend <= 0; s_drive <= 0;
      end else if (scl_bus && p_scl && !p_sda && sda_bus) begin
         s_bit <= 0; s_tx <= 0; s_drive <= 0;
      end else if (scl_bus && !p_scl) begin
         s_last <= cyc;
         if (s_bit == 1 && s_byte == 0) s_gap <= cyc - s_last;
         if (s_bit < 8) begin
            s_sh <= {s_sh[6:0], sda_bus};
            s_bit <= s_bit + 1;
         end else begin
            if (s_tx) s_mack <= sda_bus;
            s_bit <= 9;
         end
      end else if (!scl_bus && p_scl) begin
         if (s_bit == 8) begin
            if (s_tx) s_drive <= 0;
            else begin
               s_nb <= s_nb + 1;
               case (s_byte)
                  3'd0: begin
                     s_drive <= (s_sh[7:1] == SLV);
                     s_pend  <= (s_sh[7:1] == SLV) && s_sh[0];
                  end
                  3'd1: begin s_idx <= s_sh; s_drive <= (nack_sel != 2'd2); end
                  default: begin s_dat <= s_sh; s_drive <= (nack_sel != 2'd3); end
               endcase
            end
         end else if (s_bit == 9) begin
            s_bit <= 0;
            s_byte <= s_byte + 1;
            if (s_pend && !s_tx) begin
               s_tx <= 1; s_out <= rd_val; s_drive <= !rd_val[7];
            end else begin
               s_tx <= 0; s_pend <= 0; s_drive <= 0;
            end
         end else if (s_tx && s_bit >= 1 && s_bit <= 7) begin
            s_drive <= !s_out[3'd7 - s_bit[2:0]];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] st;
      for (int i = 0; i < 4000; i++) begin
         rd_reg(2'd3, st);
         if (!st[0]) break;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd_reg(a[1:0], v);
         chk("R1 reg after reset", v, 8'h00);
      end
      chk("R1 lines released", {scl_drive_low, sda_drive_low}, 2'b00);

      // R10 readback of index and data
      wr_reg(2'd1, 8'h5C); rd_reg(2'd1, v); chk("R10 index readback", v, 8'h5C);
      wr_reg(2'd0, 8'hE7); rd_reg(2'd0, v); chk("R10 data readback", v, 8'hE7);

      // table of transfers
      for (int k = 0; k < NV; k++) begin
         logic rw; logic [6:0] ad; logic [7:0] ix, dt; logic err_e;
         int st0, nb0, nb_e, st_e;
         {rw, ad, ix, dt, nack_sel} = VEC[k];
         err_e = (ad != SLV) || (nack_sel == 2'd2) || (nack_sel == 2'd3 && !rw);
         nb_e  = (ad != SLV) ? 1 : (nack_sel == 2'd2) ? 2 : 3;
         st_e  = (rw && !err_e) ? 2 : 1;
         st0 = s_starts; nb0 = s_nb;
         wr_reg(2'd1, ix);
         wr_reg(2'd0, dt);
         wr_reg(2'd2, {ad, rw});
         rd_reg(2'd3, v);
         chk("R2 busy after launch", v[0], 1'b1);
         rd_reg(2'd2, v);
         chk("R2 selector readback", v, {ad, rw});
         wait_idle();
         rd_reg(2'd3, v);
         chk("R5 error flag", v[2], err_e);
         chk("R4 valid flag", v[1], rw && !err_e);
         chk("R5 busy cleared", v[0], 1'b0);
         chk("R5 bytes seen by slave", s_nb - nb0, nb_e);
         chk("R4 start count", s_starts - st0, st_e);
         chk("R9 idle lines", {scl_drive_low, sda_drive_low}, 2'b00);
         if (nb_e >= 2) chk("R3 index on bus", s_idx, ix);
         if (!rw && nb_e == 3) chk("R3 data on bus", s_dat, dt);
         if (rw && !err_e) begin
            rd_reg(2'd0, v);
            chk("R4 received byte", v, ix ^ 8'h5A);
            chk("R4 master ack low", s_mack, 1'b0);
         end
         chk("R8 scl bit period", s_gap, BITP);
         wr_reg(2'd3, 8'h06);
         rd_reg(2'd3, v);
         chk("R6 flags cleared", v, 8'h00);
      end

      // R6 sticky: a zero or the other bit leaves valid set
      nack_sel = 2'd0;
      wr_reg(2'd1, 8'h11);
      wr_reg(2'd2, {SLV, 1'b1});
      wait_idle();
      wr_reg(2'd3, 8'h00); rd_reg(2'd3, v); chk("R6 zero write keeps valid", v[1], 1'b1);
      wr_reg(2'd3, 8'h04); rd_reg(2'd3, v); chk("R6 err-bit write keeps valid", v[1], 1'b1);
      wr_reg(2'd3, 8'h02); rd_reg(2'd3, v); chk("R6 one write clears valid", v[1], 1'b0);
      // R6 sticky error
      wr_reg(2'd2, {7'h33, 1'b0});
      wait_idle();
      wr_reg(2'd3, 8'h02); rd_reg(2'd3, v); chk("R6 valid-bit write keeps err", v[2], 1'b1);
      wr_reg(2'd3, 8'h04); rd_reg(2'd3, v); chk("R6 one write clears err", v[2], 1'b0);

      // R7 selector write while busy is ignored
      begin
         int st0, nb0;
         st0 = s_starts; nb0 = s_nb;
         wr_reg(2'd1, 8'h66);
         wr_reg(2'd0, 8'h99);
         wr_reg(2'd2, {SLV, 1'b0});
         wr_reg(2'd2, {7'h2A, 1'b1});
         rd_reg(2'd2, v);
         chk("R7 selector unchanged", v, {SLV, 1'b0});
         wait_idle();
         chk("R7 single start", s_starts - st0, 1);
         chk("R7 full write done", s_nb - nb0, 3);
         chk("R7 data kept", s_dat, 8'h99);
         rd_reg(2'd3, v);
         chk("R7 no error", v, 8'h00);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule